// File: doc/BRIEF.md
# Dual-Pointer Indirect Addressing Unit

This block sits beside a small CPU's register file and turns accesses to a window of virtual register addresses into indirect data-memory accesses. It holds two 10-bit address pointers. Each pointer is reached through five aliased virtual addresses. The alias that is touched decides two things: which address goes to data memory, and how the pointer moves afterwards. The five behaviours are: leave the pointer alone, step it up after the access, step it down after the access, step it up before the access, or add the working register to form the address without moving the pointer.

The CPU presents a register address, read and write strobes, write data and the current working-register value, all in one cycle. In that same cycle the block drives the effective data-memory address and a select flag. The pointer update lands on the next clock edge. The CPU can also read and write each pointer directly as a low byte and a high byte. The high byte holds only the two top pointer bits. The data memory, the CPU datapath and bank selection live outside this block.

Top module: `fsr_indirect_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, both pointers are 0, `mem_sel` is 0, `mem_addr` is 0 and `reg_rdata` is 0.
- R2: An access (read, write or both) to address 0x00..0x04 uses pointer 0, and an access to 0x05..0x09 uses pointer 1. Within each group the offset selects the mode: 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment, 4 offset by W. During such an access `mem_sel` is 1. When no indirect access is present, `mem_sel` and `mem_addr` are 0.
- R3: In post-increment mode, `mem_addr` is the old pointer, and after the clock edge the pointer is the old value plus 1.
- R4: In post-decrement mode, `mem_addr` is the old pointer, and after the clock edge the pointer is the old value minus 1.
- R5: In pre-increment mode, `mem_addr` is the old pointer plus 1, and after the clock edge the pointer holds that same value.
- R6: In offset mode, `mem_addr` is the pointer plus the working register taken as unsigned, and the pointer does not change. In plain mode, `mem_addr` is the pointer and the pointer does not change.
- R7: All pointer and address arithmetic wraps modulo 1024.
- R8: A write to 0x10 or 0x12 loads the low 8 bits of pointer 0 or pointer 1. A write to 0x0F or 0x11 loads pointer bits 9:8 from write-data bits 1:0, and write-data bits 7:2 are ignored. A direct write to a pointer byte takes priority over any indirect update of that byte in the same cycle.
- R9: A read of 0x0F/0x11 returns {6'b0, pointer[9:8]}, and a read of 0x10/0x12 returns pointer[7:0], in the same cycle. Otherwise `reg_rdata` is 0.
- R10: An indirect access applies its pointer side effect exactly once, even when read and write are both high. A cycle with no strobe, or an access to an unmapped address such as 0x0A, changes no pointer and raises no `mem_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | CPU register-file address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data for direct pointer-byte writes |
| wreg | input | 8 | Working-register value for offset mode |
| mem_sel | output | 1 | An indirect data-memory access is in progress |
| mem_addr | output | 10 | Effective data-memory address |
| reg_rdata | output | 8 | Direct pointer-byte read data |
| ptr_vals | output | 20 | Current pointers, pointer 1 in bits 19:10, pointer 0 in bits 9:0 |

## Verification
The assertions assume that the CPU drives at most one register address per cycle. Under that assumption a direct pointer write and an indirect access can only coincide through the priority path. The assertions also assume that the strobes and address are stable around the clock edge. The stimulus changes every input on the falling edge and holds it through the next rising edge. It never drives an address outside the decoded window together with an expected side effect, so every transition an assertion watches comes from one well-defined access.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_OFFSETW = 3'd4
    } amode_e;

    localparam int MODES_PER_PTR = 5;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
    import fsr_pkg::*;
#(
    parameter int NUM_PTR  = 2,
    parameter int ADDR_W   = 8,
    parameter int IND_BASE = 0,
    parameter int DIR_BASE = 15
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    output logic [NUM_PTR-1:0] ind_hit,
    output amode_e             mode,
    output logic [NUM_PTR-1:0] hi_wr,
    output logic [NUM_PTR-1:0] lo_wr,
    output logic [NUM_PTR-1:0] hi_rd,
    output logic [NUM_PTR-1:0] lo_rd
);
    logic access;
    assign access = rd | wr;

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_dec
        localparam int LO_A = IND_BASE + p * MODES_PER_PTR;
        localparam int HI_A = DIR_BASE + 2 * p;
        assign ind_hit[p] = access && (addr >= ADDR_W'(LO_A))
                                   && (addr <  ADDR_W'(LO_A + MODES_PER_PTR));
        assign hi_wr[p] = wr && (addr == ADDR_W'(HI_A));
        assign lo_wr[p] = wr && (addr == ADDR_W'(HI_A + 1));
        assign hi_rd[p] = rd && (addr == ADDR_W'(HI_A));
        assign lo_rd[p] = rd && (addr == ADDR_W'(HI_A + 1));
    end

    always_comb begin
        mode = AM_PLAIN;
        for (int p = 0; p < NUM_PTR; p++) begin
            if (ind_hit[p]) begin
                mode = amode_e'(3'(addr - ADDR_W'(IND_BASE + p * MODES_PER_PTR)));
            end
        end
    end
endmodule

// File: rtl/fsr_ptr.sv
module fsr_ptr
    import fsr_pkg::*;
#(
    parameter int PTR_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_en,
    input  amode_e            mode,
    input  logic [DATA_W-1:0] wreg,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [PTR_W-1:0]  eff_addr,
    output logic [DATA_W-1:0] rd_hi,
    output logic [DATA_W-1:0] rd_lo
);
    localparam int HI_W = PTR_W - DATA_W;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } state_t;

    state_t st_q, st_d;
    logic [PTR_W-1:0] upd;

    always_comb begin
        upd      = st_q.ptr;
        eff_addr = st_q.ptr;
        if (ind_en) begin
            unique case (mode)
                AM_POSTINC: upd = st_q.ptr + PTR_W'(1);
                AM_POSTDEC: upd = st_q.ptr - PTR_W'(1);
                AM_PREINC: begin
                    upd      = st_q.ptr + PTR_W'(1);
                    eff_addr = upd;
                end
                AM_OFFSETW: eff_addr = st_q.ptr + PTR_W'(wreg);
                default:    upd = st_q.ptr;
            endcase
        end
        st_d.ptr = upd;
        if (wr_lo) st_d.ptr[DATA_W-1:0]     = wdata;
        if (wr_hi) st_d.ptr[PTR_W-1:DATA_W] = wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q = st_q.ptr;
    assign rd_hi = DATA_W'(st_q.ptr[PTR_W-1:DATA_W]);
    assign rd_lo = st_q.ptr[DATA_W-1:0];

    a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ind_en && mode == AM_POSTINC && !wr_hi && !wr_lo
        |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));

    a_r4_postdec_step: assert property (@(posedge clk) disable iff (!rst_n)
        ind_en && mode == AM_POSTDEC && !wr_hi && !wr_lo
        |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));

    a_r5_preinc_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ind_en && mode == AM_PREINC && !wr_hi && !wr_lo
        |=> ptr_q == $past(eff_addr));

    a_r6_offset_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ind_en && mode == AM_OFFSETW && !wr_hi && !wr_lo |=> $stable(ptr_q));

    a_r8_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ptr_q[DATA_W-1:0] == $past(wdata));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_en && !wr_hi && !wr_lo |=> $stable(ptr_q));
endmodule

// File: rtl/fsr_indirect_unit.sv
module fsr_indirect_unit
    import fsr_pkg::*;
#(
    parameter int NUM_PTR  = 2,
    parameter int PTR_W    = 10,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8,
    parameter int IND_BASE = 0,
    parameter int DIR_BASE = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_rd,
    input  logic                     reg_wr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic [DATA_W-1:0]        wreg,
    output logic                     mem_sel,
    output logic [PTR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NUM_PTR*PTR_W-1:0] ptr_vals
);
    logic [NUM_PTR-1:0] ind_hit, hi_wr, lo_wr, hi_rd, lo_rd;
    amode_e             mode;
    logic [PTR_W-1:0]   eff  [NUM_PTR];
    logic [DATA_W-1:0]  b_hi [NUM_PTR];
    logic [DATA_W-1:0]  b_lo [NUM_PTR];

    fsr_decode #(
        .NUM_PTR (NUM_PTR), .ADDR_W (ADDR_W),
        .IND_BASE(IND_BASE), .DIR_BASE(DIR_BASE)
    ) u_dec (
        .addr   (reg_addr), .rd(reg_rd), .wr(reg_wr),
        .ind_hit(ind_hit),  .mode(mode),
        .hi_wr  (hi_wr),    .lo_wr(lo_wr),
        .hi_rd  (hi_rd),    .lo_rd(lo_rd)
    );

    for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
        fsr_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ind_en  (ind_hit[p]),
            .mode    (mode),
            .wreg    (wreg),
            .wr_hi   (hi_wr[p]),
            .wr_lo   (lo_wr[p]),
            .wdata   (reg_wdata),
            .ptr_q   (ptr_vals[p*PTR_W +: PTR_W]),
            .eff_addr(eff[p]),
            .rd_hi   (b_hi[p]),
            .rd_lo   (b_lo[p])
        );
    end

    always_comb begin
        mem_addr  = '0;
        reg_rdata = '0;
        for (int p = 0; p < NUM_PTR; p++) begin
            if (ind_hit[p]) mem_addr  = eff[p];
            if (hi_rd[p])   reg_rdata = b_hi[p];
            if (lo_rd[p])   reg_rdata = b_lo[p];
        end
    end

    assign mem_sel = |ind_hit;

    a_r2_one_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ind_hit));

    a_r2_idle_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel |-> mem_addr == '0);

    a_r9_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);

    a_r10_no_access_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd && !reg_wr |-> !mem_sel);
endmodule

// File: tb/fsr_indirect_unit_bench.sv
`timescale 1ns/1ps
module fsr_indirect_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, wreg = '0;
    logic       mem_sel;
    logic [9:0] mem_addr;
    logic [7:0] reg_rdata;
    logic [19:0] ptr_vals;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    fsr_indirect_unit u_fsr_indirect_unit (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .wreg(wreg),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .reg_rdata(reg_rdata),
        .ptr_vals(ptr_vals)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] addr;
        logic       rd;
        logic       wr;
        logic [7:0] wdata;
        logic [7:0] w;
        logic       esel;
        logic [9:0] emem;
        logic [7:0] erd;
        logic [9:0] ep0;
        logic [9:0] ep1;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{8'd8,  8'h10, 1'b0, 1'b1, 8'hFE, 8'h00, 1'b0, 10'h000, 8'h00, 10'h0FE, 10'h000}, // R8 lo write
        '{8'd8,  8'h0F, 1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, 10'h000, 8'h00, 10'h3FE, 10'h000}, // R8 hi bits 7:2 ignored
        '{8'd3,  8'h01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h3FE, 8'h00, 10'h3FF, 10'h000}, // R3
        '{8'd7,  8'h01, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 10'h3FF, 8'h00, 10'h000, 10'h000}, // R7 wrap up
        '{8'd4,  8'h02, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h000, 8'h00, 10'h3FF, 10'h000}, // R4 and wrap down
        '{8'd5,  8'h03, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h000, 8'h00, 10'h000, 10'h000}, // R5 wrap
        '{8'd6,  8'h04, 1'b1, 1'b0, 8'h00, 8'h80, 1'b1, 10'h080, 8'h00, 10'h000, 10'h000}, // R6
        '{8'd8,  8'h12, 1'b0, 1'b1, 8'h55, 8'h00, 1'b0, 10'h000, 8'h00, 10'h000, 10'h055}, // R8
        '{8'd8,  8'h11, 1'b0, 1'b1, 8'h02, 8'h00, 1'b0, 10'h000, 8'h00, 10'h000, 10'h255}, // R8
        '{8'd2,  8'h05, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h255, 8'h00, 10'h000, 10'h255}, // R2 plain ptr1
        '{8'd6,  8'h09, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 10'h354, 8'h00, 10'h000, 10'h255}, // R6 unsigned W
        '{8'd5,  8'h08, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h256, 8'h00, 10'h000, 10'h256}, // R5 ptr1
        '{8'd4,  8'h07, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 10'h256, 8'h00, 10'h000, 10'h255}, // R4 ptr1
        '{8'd3,  8'h06, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h255, 8'h00, 10'h000, 10'h256}, // R3 ptr1
        '{8'd9,  8'h11, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 10'h000, 8'h02, 10'h000, 10'h256}, // R9
        '{8'd9,  8'h12, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 10'h000, 8'h56, 10'h000, 10'h256}, // R9
        '{8'd8,  8'h0F, 1'b0, 1'b1, 8'hFD, 8'h00, 1'b0, 10'h000, 8'h00, 10'h100, 10'h256}, // R8
        '{8'd9,  8'h0F, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 10'h000, 8'h01, 10'h100, 10'h256}, // R9 upper zeros
        '{8'd10, 8'h0A, 1'b1, 1'b1, 8'hAA, 8'h00, 1'b0, 10'h000, 8'h00, 10'h100, 10'h256}, // R10 unmapped
        '{8'd10, 8'h01, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 10'h100, 8'h00, 10'h101, 10'h256}, // R10 once
        '{8'd10, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 10'h000, 8'h00, 10'h101, 10'h256}, // R10 no strobe
        '{8'd6,  8'h04, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1, 10'h200, 8'h00, 10'h101, 10'h256}, // R6
        '{8'd8,  8'h0F, 1'b0, 1'b1, 8'h03, 8'h00, 1'b0, 10'h000, 8'h00, 10'h301, 10'h256}, // R8
        '{8'd8,  8'h10, 1'b0, 1'b1, 8'hF0, 8'h00, 1'b0, 10'h000, 8'h00, 10'h3F0, 10'h256}, // R8
        '{8'd7,  8'h04, 1'b1, 1'b0, 8'h00, 8'h20, 1'b1, 10'h010, 8'h00, 10'h3F0, 10'h256}, // R7 offset wraps
        '{8'd2,  8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h3F0, 8'h00, 10'h3F0, 10'h256}  // R2 plain ptr0
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(1, "ptr during reset", ptr_vals, 0);
        chk(1, "sel during reset", mem_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "ptr after reset", ptr_vals, 0);
        chk(1, "rdata after reset", reg_rdata, 0);
        chk(1, "addr after reset", mem_addr, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_addr  = VEC[i].addr;
            reg_rd    = VEC[i].rd;
            reg_wr    = VEC[i].wr;
            reg_wdata = VEC[i].wdata;
            wreg      = VEC[i].w;
            #2;
            chk(VEC[i].req, "mem_sel", mem_sel, VEC[i].esel);
            chk(VEC[i].req, "mem_addr", mem_addr, VEC[i].emem);
            chk(VEC[i].req, "reg_rdata", reg_rdata, VEC[i].erd);
            @(posedge clk);
            #1;
            chk(VEC[i].req, "ptr0", ptr_vals[9:0], VEC[i].ep0);
            chk(VEC[i].req, "ptr1", ptr_vals[19:10], VEC[i].ep1);
        end

        // R1: reset in mid-run clears both pointers
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(1, "ptr after mid-run reset", ptr_vals, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R5: pre-increment from zero after reset on ptr1
        reg_addr = 8'h08; reg_rd = 1'b1;
        #2;
        chk(5, "preinc addr", mem_addr, 10'h001);
        @(posedge clk);
        #1;
        chk(5, "preinc ptr1", ptr_vals[19:10], 10'h001);
        @(negedge clk);
        reg_rd = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule